// File: doc/BRIEF.md
# Shared Sequential Multiply/Divide Unit

This block is an iterative integer arithmetic engine. It computes a 64-bit product or a 32-bit quotient and remainder from two 32-bit operands, signed or unsigned. Both operations use the same double-width working register and the same adder. A multiply retires one partial-product bit per clock. A divide works by the restoring method and produces one quotient bit per clock. When an operation completes, the result is written into a pair of result registers, `hi` and `lo`.

To launch an operation, a client raises `start` for one cycle while the unit is idle. The same cycle must present the operation code on `op`, the first operand on `rs` (the multiplier or the dividend) and the second operand on `rt` (the multiplicand or the divisor). The unit then holds `busy` high for a fixed number of cycles. When the result registers take the new value, `done` pulses for one cycle. The unit does no checking for a zero divisor or for quotient overflow. It still finishes on schedule in those cases, but the values it leaves in `hi`/`lo` are not defined.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst_n` is low, `hi`, `lo`, `busy` and `done` are all zero.
- R2: A `start` seen at a rising edge while `busy` is low begins an operation. `busy` is then high for exactly W+1 cycles (33 at W=32). `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low again.
- R3: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands, its operation code and its cycle count.
- R4: With `op` = 2'b01 (unsigned multiply), `{hi,lo}` becomes the 64-bit unsigned product `rs*rt`.
- R5: With `op` = 2'b00 (signed multiply), `{hi,lo}` becomes the 64-bit two's-complement product of `rs` and `rt`, both taken as signed.
- R6: With `op` = 2'b11 (unsigned divide), `lo` becomes the quotient `rs/rt` and `hi` becomes the remainder `rs%rt`.
- R7: With `op` = 2'b10 (signed divide), the quotient is truncated toward zero and is negative when the operand signs differ. The remainder has the sign of the dividend `rs`.
- R8: `hi` and `lo` change only in the cycle in which `done` is high. At all other times they hold their value, whatever the inputs do.
- R9: During a divide with a nonzero divisor, the partial remainder is less than the divisor after every step. Every unsigned remainder is therefore less than `rt`.
- R10: A divide by zero still completes in the same W+1 busy cycles and raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, taken only while idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| rs | input | 32 | Multiplier or dividend |
| rt | input | 32 | Multiplicand or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper product half, or remainder |
| lo | output | 32 | Lower product half, or quotient |

## Verification
The remainder-bound assertion holds only for a nonzero divisor. It also relies on the divisor register staying unchanged while an operation runs, and it is therefore guarded on the captured divisor. The stimulus keeps away from the signed case of the most negative dividend divided by minus one, whose quotient cannot be represented. A zero divisor is driven only in the test of R10, and that test looks at timing alone. All inputs are changed on the falling clock edge, so each `start` is seen cleanly at exactly one rising edge. Operands that are not applied with a `start` are deliberately changed while the unit is idle, to show that they have no effect.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_MULS = 2'b00,
      OP_MULU = 2'b01,
      OP_DIVS = 2'b10,
      OP_DIVU = 2'b11
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIX  = 2'b10
   } md_state_e;

endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep #(
   parameter int W = 32
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   output logic [W-1:0] mag_a,
   output logic [W-1:0] mag_b,
   output logic         neg_low,
   output logic         neg_high
);
   import muldiv_pkg::*;

   if (W < 4) begin : g_bad_width
      $error("md_sign_prep: W must be at least 4");
   end

   logic         is_signed;
   logic         is_div;
   logic [1:0]   neg_in;
   logic [W-1:0] raw [2];
   logic [W-1:0] mag [2];

   assign is_signed = (op == OP_MULS) || (op == OP_DIVS);
   assign is_div    = op[1];
   assign raw[0]    = opnd_a;
   assign raw[1]    = opnd_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_abs
      assign neg_in[gi] = is_signed & raw[gi][W-1];
      assign mag[gi]    = neg_in[gi] ? (~raw[gi] + W'(1)) : raw[gi];
   end

   assign mag_a    = mag[0];
   assign mag_b    = mag[1];
   assign neg_low  = neg_in[0] ^ neg_in[1];
   assign neg_high = is_div ? neg_in[0] : (neg_in[0] ^ neg_in[1]);

endmodule

// File: rtl/md_ctrl.sv
module md_ctrl #(
   parameter int W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic step,
   output logic finish,
   output logic busy,
   output logic done
);
   import muldiv_pkg::*;

   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   if (W < 4 || (1 << CW) != W) begin : g_bad_width
      $error("md_ctrl: W must be a power of two, at least 4");
   end

   md_state_e     state;
   logic [CW-1:0] cnt;

   assign busy   = (state != ST_IDLE);
   assign accept = start && (state == ST_IDLE);
   assign step   = (state == ST_RUN);
   assign finish = (state == ST_FIX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= finish;
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_RUN;
               cnt   <= '0;
            end
            ST_RUN: begin
               cnt <= cnt + CW'(1);
               if (cnt == LAST) state <= ST_FIX;
            end
            ST_FIX:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_RUN_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (step && cnt == '0)); // R2
   AST_FIX_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt == LAST) |=> finish); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_BUSY_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)); // R2

endmodule

// File: rtl/md_datapath.sv
module md_datapath #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic           is_div,
   input  logic [W-1:0]   init_a,
   input  logic [W-1:0]   init_b,
   output logic [2*W-1:0] acc
);
   localparam int AW = W + 2;

   if (W < 4) begin : g_bad_width
      $error("md_datapath: W must be at least 4");
   end

   logic [W-1:0]   b_q;
   logic [AW-1:0]  add_a;
   logic [AW-1:0]  add_b;
   logic [AW-1:0]  sum;
   logic           rem_neg;
   logic [2*W-1:0] acc_nxt;

   // One adder serves both operations: add for multiply, subtract for divide.
   always_comb begin
      if (is_div) begin
         add_a = {1'b0, acc[2*W-1:W-1]};
         add_b = ~{2'b00, b_q};
      end else begin
         add_a = {2'b00, acc[2*W-1:W]};
         add_b = acc[0] ? {2'b00, b_q} : '0;
      end
   end

   assign sum     = add_a + add_b + AW'(is_div);
   assign rem_neg = sum[AW-1];

   always_comb begin
      if (!is_div)
         acc_nxt = {sum[W:0], acc[W-1:1]};
      else if (rem_neg)
         acc_nxt = {acc[2*W-2:0], 1'b0};
      else
         acc_nxt = {sum[W-1:0], acc[W-2:0], 1'b1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         b_q <= '0;
      end else if (load) begin
         acc <= {{W{1'b0}}, init_a};
         b_q <= init_b;
      end else if (step) begin
         acc <= acc_nxt;
      end
   end

   AST_DIV_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_div && b_q != '0) |=> (acc[2*W-1:W] < b_q)); // R9
   AST_OPERAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> $stable(b_q)); // R3

endmodule

// File: rtl/md_fixup.sv
module md_fixup #(
   parameter int W = 32
) (
   input  logic [2*W-1:0] acc,
   input  logic           is_div,
   input  logic           neg_low,
   input  logic           neg_high,
   output logic [W-1:0]   hi_n,
   output logic [W-1:0]   lo_n
);
   logic [2*W-1:0] prod;
   logic [W-1:0]   quo;
   logic [W-1:0]   rem;

   assign prod = neg_low  ? (~acc + (2*W)'(1)) : acc;
   assign quo  = neg_low  ? (~acc[W-1:0] + W'(1)) : acc[W-1:0];
   assign rem  = neg_high ? (~acc[2*W-1:W] + W'(1)) : acc[2*W-1:W];

   assign hi_n = is_div ? rem : prod[2*W-1:W];
   assign lo_n = is_div ? quo : prod[W-1:0];

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] rs,
   input  logic [W-1:0] rt,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] hi,
   output logic [W-1:0] lo
);
   if (W < 4) begin : g_bad_width
      $error("muldiv_unit: W must be at least 4");
   end

   logic           accept, step, finish;
   logic [W-1:0]   mag_a, mag_b;
   logic           neg_low_c, neg_high_c;
   logic           neg_low_q, neg_high_q, is_div_q;
   logic [1:0]     op_q;
   logic [2*W-1:0] acc;
   logic [W-1:0]   hi_n, lo_n;

   md_sign_prep #(.W(W)) u_prep (
      .op(op), .opnd_a(rs), .opnd_b(rt),
      .mag_a(mag_a), .mag_b(mag_b),
      .neg_low(neg_low_c), .neg_high(neg_high_c)
   );

   md_ctrl #(.W(W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .accept(accept), .step(step), .finish(finish),
      .busy(busy), .done(done)
   );

   md_datapath #(.W(W)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
      .is_div(is_div_q), .init_a(mag_a), .init_b(mag_b), .acc(acc)
   );

   md_fixup #(.W(W)) u_fix (
      .acc(acc), .is_div(is_div_q),
      .neg_low(neg_low_q), .neg_high(neg_high_q),
      .hi_n(hi_n), .lo_n(lo_n)
   );

   assign is_div_q = op_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q       <= '0;
         neg_low_q  <= 1'b0;
         neg_high_q <= 1'b0;
      end else if (accept) begin
         op_q       <= op;
         neg_low_q  <= neg_low_c;
         neg_high_q <= neg_high_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (finish) begin
         hi <= hi_n;
         lo <= lo_n;
      end
   end

   AST_START_WHILE_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(op_q) && $stable(neg_low_q) && $stable(neg_high_q))); // R3
   AST_HILO_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ((hi != $past(hi)) || (lo != $past(lo))) |-> done); // R8
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!busy && !done && hi == '0 && lo == '0)); // R1

endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [W-1:0] rs = '0;
   logic [W-1:0] rt = '0;
   logic         busy, done;
   logic [W-1:0] hi, lo;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   muldiv_unit #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rs(rs), .rt(rt),
      .busy(busy), .done(done), .hi(hi), .lo(lo)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog: run hung, act=%0d exp<=100000 cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // Launch an operation and wait until busy drops; returns busy cycle count.
   task automatic launch(input logic [1:0] o, input logic [W-1:0] a,
                         input logic [W-1:0] b, input bit disturb, output int n);
      @(negedge clk);
      start = 1'b1; op = o; rs = a; rt = b;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (busy && n < 200) begin
         n++;
         if (disturb && n == 5) begin
            start = 1'b1; op = ~o; rs = ~a; rt = b + 32'd3;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic exp_mul(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b,
                          output logic [63:0] r);
      if (sgn) r = 64'(longint'($signed(a)) * longint'($signed(b)));
      else     r = 64'({32'b0, a}) * 64'({32'b0, b});
   endtask

   task automatic test_reset();
      chk(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'd0);
      chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
      chk({hi, lo} == 64'd0, "R1", "hi:lo in reset", {hi, lo}, 64'd0);
   endtask

   task automatic test_mul(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
      int n;
      logic [63:0] e;
      exp_mul(sgn, a, b, e);
      launch(sgn ? 2'b00 : 2'b01, a, b, 1'b0, n);
      chk(n == W + 1, "R2", "busy cycles", 64'(n), 64'(W + 1));
      chk(done == 1'b1, "R2", "done after busy", 64'(done), 64'd1);
      chk({hi, lo} == e, sgn ? "R5" : "R4", "product", {hi, lo}, e);
      @(negedge clk);
      chk(done == 1'b0, "R2", "done single cycle", 64'(done), 64'd0);
   endtask

   task automatic test_div(input bit sgn, input logic [W-1:0] a, input logic [W-1:0] b);
      int n;
      logic [W-1:0] q, r;
      if (sgn) begin
         q = W'($signed(a) / $signed(b));
         r = W'($signed(a) % $signed(b));
      end else begin
         q = a / b;
         r = a % b;
      end
      launch(sgn ? 2'b10 : 2'b11, a, b, 1'b0, n);
      chk(n == W + 1, "R2", "busy cycles div", 64'(n), 64'(W + 1));
      chk(done == 1'b1, "R2", "done after div", 64'(done), 64'd1);
      chk(lo == q, sgn ? "R7" : "R6", "quotient", 64'(lo), 64'(q));
      chk(hi == r, sgn ? "R7" : "R6", "remainder", 64'(hi), 64'(r));
      if (!sgn) chk(hi < b, "R9", "remainder below divisor", 64'(hi), 64'(b));
   endtask

   task automatic test_start_ignored();
      int n;
      logic [63:0] e;
      exp_mul(1'b0, 32'd123457, 32'd98765, e);
      launch(2'b01, 32'd123457, 32'd98765, 1'b1, n);
      chk(n == W + 1, "R3", "busy cycles with extra start", 64'(n), 64'(W + 1));
      chk({hi, lo} == e, "R3", "result of first op kept", {hi, lo}, e);
   endtask

   task automatic test_hold();
      logic [63:0] snap;
      snap = {hi, lo};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         op = 2'(i); rs = 32'hA5A5_0000 + 32'(i); rt = 32'h0000_5A5A ^ 32'(i);
      end
      chk({hi, lo} == snap, "R8", "hi:lo hold while idle", {hi, lo}, snap);
      chk(busy == 1'b0, "R8", "no launch without start", 64'(busy), 64'd0);
   endtask

   task automatic test_div_zero();
      int n;
      launch(2'b11, 32'd77, 32'd0, 1'b0, n);
      chk(n == W + 1, "R10", "busy cycles div by zero", 64'(n), 64'(W + 1));
      chk(done == 1'b1, "R10", "done after div by zero", 64'(done), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_mul(1'b0, 32'd7, 32'd6);
      test_mul(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      test_mul(1'b0, 32'h8000_0001, 32'd0);
      test_mul(1'b1, -32'sd3, 32'sd5);
      test_mul(1'b1, -32'sd1, -32'sd1);
      test_mul(1'b1, 32'h8000_0000, 32'h8000_0000);
      test_mul(1'b1, 32'h7FFF_FFFF, -32'sd2);
      test_div(1'b0, 32'd100, 32'd7);
      test_div(1'b0, 32'hFFFF_FFFF, 32'd1);
      test_div(1'b0, 32'd5, 32'd9);
      test_div(1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
      test_div(1'b1, -32'sd7, 32'sd2);
      test_div(1'b1, 32'sd7, -32'sd2);
      test_div(1'b1, -32'sd7, -32'sd2);
      test_div(1'b1, 32'h8000_0000, 32'sd3);
      test_start_ignored();
      test_hold();
      test_div_zero();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule